// File: doc/BRIEF.md
# Iterative Integer Multiply/Divide Unit

This block performs 32-bit integer multiplication and division beside a processor pipeline. A one-cycle start pulse carries an operation code and two operands. The unit then works through one bit per cycle and writes its answer into two architectural result registers, here called the high and low result registers. A multiply leaves the full double-width product in the pair. A divide leaves the quotient in the low register and the remainder in the high register.

The issuing pipeline keeps running while the unit works. It is held back only when it asks to read either result register before the operation has finished, which the unit signals on `stall_o`. Software can also load either result register directly through its own write port. Divide-by-zero raises no trap: it finishes in the normal time and leaves arbitrary values behind.

Top module: `muldiv_unit`

## Requirements
- R1: Operation code 2'b01 (unsigned multiply) leaves bits 63..32 of the unsigned 64-bit product of `a_i` and `b_i` in `hi_o` and bits 31..0 in `lo_o`.
- R2: Operation code 2'b00 (signed multiply) leaves the two's-complement 64-bit product of the signed operands, with the upper half in `hi_o` and the lower half in `lo_o`.
- R3: Operation code 2'b11 (unsigned divide of `a_i` by `b_i`) leaves the quotient in `lo_o` and the remainder in `hi_o`.
- R4: Operation code 2'b10 (signed divide) rounds the quotient toward zero, and the remainder carries the sign of the dividend. The quotient of -2^31 divided by -1 wraps to 32'h8000_0000 and the remainder is 0.
- R5: `busy_o` goes high on the clock edge that accepts a start. It stays high for exactly 33 cycles (one per operand bit plus one sign-correction cycle), and the results appear on `hi_o`/`lo_o` on the edge where it falls.
- R6: A start pulse while `busy_o` is high is ignored: the running operation ends at its normal time with its own result, and no second operation follows.
- R7: `stall_o` is high exactly when `busy_o` is high and `rd_hi_i` or `rd_lo_i` is asserted. It is low whenever the unit is idle.
- R8: While idle, `hi_we_i` loads `hi_wdata_i` into `hi_o` and `lo_we_i` loads `lo_wdata_i` into `lo_o` at the next edge. Each write leaves the other register unchanged.
- R9: When a direct write falls on the same edge as an operation's completion, the operation's result is the value that is kept.
- R10: A divide by zero, signed or unsigned, completes with the same 33-cycle busy window as any other operation.
- R11: After reset, `busy_o` and `stall_o` are low and `hi_o` and `lo_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted only while idle |
| op_i | input | 2 | Operation: 00 signed mul, 01 unsigned mul, 10 signed div, 11 unsigned div |
| a_i | input | 32 | Multiplicand or dividend |
| b_i | input | 32 | Multiplier or divisor |
| rd_hi_i | input | 1 | Pipeline wants to read the high register |
| rd_lo_i | input | 1 | Pipeline wants to read the low register |
| hi_we_i | input | 1 | Direct write enable, high register |
| hi_wdata_i | input | 32 | Direct write data, high register |
| lo_we_i | input | 1 | Direct write enable, low register |
| lo_wdata_i | input | 32 | Direct write data, low register |
| busy_o | output | 1 | Operation in progress |
| stall_o | output | 1 | Result read must wait |
| hi_o | output | 32 | High result register |
| lo_o | output | 32 | Low result register |

## Verification
The bench feeds the unit operands at the edges of the number ranges: the most negative value, minus one, all ones and mixed signs. Any slip in magnitude conversion or final negation shows up there as a wrong sign or an off-by-one high word. The signed divide cases cover every sign combination, so a remainder that takes its sign from the divisor, or a quotient that rounds toward minus infinity, is caught. The bench counts the busy window cycle by cycle, fires a second start in the middle of a run and puts a direct write on the completion edge. A counter off by one, a restarted operation, or a completion that loses to a direct write each produces a wrong count or a wrong register value.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

  // Operation code: bit 1 selects divide, bit 0 selects unsigned
  typedef enum logic [1:0] {
    OP_MUL_S = 2'b00,
    OP_MUL_U = 2'b01,
    OP_DIV_S = 2'b10,
    OP_DIV_U = 2'b11
  } md_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_ITER = 2'b01,
    ST_FIX  = 2'b10
  } md_state_e;

endpackage

// File: rtl/muldiv_ctrl.sv
module muldiv_ctrl
  import muldiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o,
  output logic load_o,
  output logic iter_o,
  output logic fix_o
);

  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  md_state_e state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_ITER;
          cnt_d   = '0;
          cnt_en  = 1'b1;
        end
      end
      ST_ITER: begin
        cnt_en = 1'b1;
        if (cnt_q == LAST) begin
          state_d = ST_FIX;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_FIX:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign load_o = (state_q == ST_IDLE) && start_i;
  assign iter_o = (state_q == ST_ITER);
  assign fix_o  = (state_q == ST_FIX);

  // R5: the last iteration hands over to the correction cycle
  p_fix_follows_iter_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (iter_o && cnt_q == LAST) |=> fix_o);

  // R5: correction cycle always ends the busy window
  p_idle_after_fix_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fix_o |=> !busy_o);

  // R6: a start during a run never reloads the datapath
  p_no_reload_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |-> !load_o);

endmodule

// File: rtl/muldiv_core.sv
module muldiv_core
  import muldiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         iter_i,
  input  logic         fix_i,
  input  logic [1:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] res_hi_o,
  output logic [W-1:0] res_lo_o
);

  localparam int W2 = 2 * W;

  logic [W-1:0] acc_q, acc_d;
  logic [W-1:0] low_q, low_d;
  logic [W-1:0] opnd_q;
  logic         div_q, neg_lo_q, neg_hi_q;

  // operand magnitudes at load
  logic         signed_op, a_neg, b_neg;
  logic [W-1:0] a_mag, b_mag;

  assign signed_op = ~op_i[0];
  assign a_neg     = signed_op & a_i[W-1];
  assign b_neg     = signed_op & b_i[W-1];
  assign a_mag     = a_neg ? (~a_i + 1'b1) : a_i;
  assign b_mag     = b_neg ? (~b_i + 1'b1) : b_i;

  // one iteration of shift-add or restoring shift-subtract
  logic [W:0] add_sum;
  logic [W:0] div_sh, div_diff;

  always_comb begin
    add_sum  = {1'b0, acc_q} + (low_q[0] ? {1'b0, opnd_q} : '0);
    div_sh   = {acc_q, low_q[W-1]};
    div_diff = div_sh - {1'b0, opnd_q};
    acc_d    = acc_q;
    low_d    = low_q;
    if (load_i) begin
      acc_d = '0;
      low_d = op_i[1] ? a_mag : b_mag;
    end else if (iter_i) begin
      if (div_q) begin
        if (!div_diff[W]) begin
          acc_d = div_diff[W-1:0];
          low_d = {low_q[W-2:0], 1'b1};
        end else begin
          acc_d = div_sh[W-1:0];
          low_d = {low_q[W-2:0], 1'b0};
        end
      end else begin
        acc_d = add_sum[W:1];
        low_d = {add_sum[0], low_q[W-1:1]};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      low_q <= '0;
    end else if (load_i || iter_i) begin
      acc_q <= acc_d;
      low_q <= low_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opnd_q   <= '0;
      div_q    <= 1'b0;
      neg_lo_q <= 1'b0;
      neg_hi_q <= 1'b0;
    end else if (load_i) begin
      opnd_q   <= op_i[1] ? b_mag : a_mag;
      div_q    <= op_i[1];
      neg_lo_q <= a_neg ^ b_neg;
      neg_hi_q <= a_neg;
    end
  end

  // sign correction, consumed during the fix cycle
  logic [W2-1:0] prod_raw, prod_fix;
  assign prod_raw = {acc_q, low_q};
  assign prod_fix = neg_lo_q ? (~prod_raw + 1'b1) : prod_raw;

  always_comb begin
    if (div_q) begin
      res_lo_o = neg_lo_q ? (~low_q + 1'b1) : low_q;
      res_hi_o = neg_hi_q ? (~acc_q + 1'b1) : acc_q;
    end else begin
      res_lo_o = prod_fix[W-1:0];
      res_hi_o = prod_fix[W2-1:W];
    end
  end

  // R6: the operand held for the iterations is not disturbed mid-run
  p_opnd_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (iter_i || fix_i) |=> $stable(opnd_q) && $stable(div_q));

endmodule

// File: rtl/muldiv_hilo.sv
module muldiv_hilo #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         busy_i,
  input  logic         done_i,
  input  logic [W-1:0] res_hi_i,
  input  logic [W-1:0] res_lo_i,
  input  logic         rd_hi_i,
  input  logic         rd_lo_i,
  input  logic         hi_we_i,
  input  logic [W-1:0] hi_wdata_i,
  input  logic         lo_we_i,
  input  logic [W-1:0] lo_wdata_i,
  output logic         stall_o,
  output logic [W-1:0] hi_o,
  output logic [W-1:0] lo_o
);

  logic [W-1:0] hi_q, hi_d, lo_q, lo_d;
  logic         hi_en, lo_en;

  // completion has priority over a direct write on the same edge
  always_comb begin
    hi_en = done_i | hi_we_i;
    lo_en = done_i | lo_we_i;
    hi_d  = done_i ? res_hi_i : hi_wdata_i;
    lo_d  = done_i ? res_lo_i : lo_wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
    end else if (hi_en) begin
      hi_q <= hi_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
    end else if (lo_en) begin
      lo_q <= lo_d;
    end
  end

  assign stall_o = busy_i & (rd_hi_i | rd_lo_i);
  assign hi_o    = hi_q;
  assign lo_o    = lo_q;

  // R8: without a write source the high register holds
  p_hi_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!done_i && !hi_we_i) |=> $stable(hi_q));

  // R8: without a write source the low register holds
  p_lo_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!done_i && !lo_we_i) |=> $stable(lo_q));

  // R9: completion value is the one kept
  p_done_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_i |=> (hi_q == $past(res_hi_i)) && (lo_q == $past(res_lo_i)));

endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
  import muldiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [1:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         rd_hi_i,
  input  logic         rd_lo_i,
  input  logic         hi_we_i,
  input  logic [W-1:0] hi_wdata_i,
  input  logic         lo_we_i,
  input  logic [W-1:0] lo_wdata_i,
  output logic         busy_o,
  output logic         stall_o,
  output logic [W-1:0] hi_o,
  output logic [W-1:0] lo_o
);

  logic         load, iter, fix, busy;
  logic [W-1:0] res_hi, res_lo;

  muldiv_ctrl #(.W(W)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .start_i(start_i),
    .busy_o (busy),
    .load_o (load),
    .iter_o (iter),
    .fix_o  (fix)
  );

  muldiv_core #(.W(W)) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (load),
    .iter_i  (iter),
    .fix_i   (fix),
    .op_i    (op_i),
    .a_i     (a_i),
    .b_i     (b_i),
    .res_hi_o(res_hi),
    .res_lo_o(res_lo)
  );

  muldiv_hilo #(.W(W)) u_hilo (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy_i    (busy),
    .done_i    (fix),
    .res_hi_i  (res_hi),
    .res_lo_i  (res_lo),
    .rd_hi_i   (rd_hi_i),
    .rd_lo_i   (rd_lo_i),
    .hi_we_i   (hi_we_i),
    .hi_wdata_i(hi_wdata_i),
    .lo_we_i   (lo_we_i),
    .lo_wdata_i(lo_wdata_i),
    .stall_o   (stall_o),
    .hi_o      (hi_o),
    .lo_o      (lo_o)
  );

  assign busy_o = busy;

  // R7: an idle unit never holds off a read
  p_idle_no_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !stall_o);

endmodule

// File: tb/muldiv_unit_tb.sv
module muldiv_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [1:0]  op_i;
  logic [31:0] a_i, b_i;
  logic        rd_hi_i, rd_lo_i, hi_we_i, lo_we_i;
  logic [31:0] hi_wdata_i, lo_wdata_i;
  logic        busy_o, stall_o;
  logic [31:0] hi_o, lo_o;

  int checks = 0;
  int errors = 0;
  int busy_n;
  bit done_flag = 1'b0;

  always #5 clk = ~clk;

  muldiv_unit u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
    .a_i(a_i), .b_i(b_i), .rd_hi_i(rd_hi_i), .rd_lo_i(rd_lo_i),
    .hi_we_i(hi_we_i), .hi_wdata_i(hi_wdata_i),
    .lo_we_i(lo_we_i), .lo_wdata_i(lo_wdata_i),
    .busy_o(busy_o), .stall_o(stall_o), .hi_o(hi_o), .lo_o(lo_o)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // issue one operation and wait for completion; counts busy cycles
  task automatic run_op(logic [1:0] op, logic [31:0] a, logic [31:0] b);
    @(negedge clk);
    start_i = 1'b1; op_i = op; a_i = a; b_i = b;
    @(negedge clk);
    start_i = 1'b0;
    busy_n = 0;
    while (busy_o && busy_n < 200) begin
      busy_n++;
      @(negedge clk);
    end
  endtask

  function automatic logic [63:0] ref_res(logic [1:0] op, logic [31:0] a, logic [31:0] b);
    longint sa, sb;
    logic [63:0] ua, ub, p;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    ua = {32'd0, a};
    ub = {32'd0, b};
    case (op)
      2'b00:   p = 64'(sa * sb);
      2'b01:   p = ua * ub;
      2'b10:   p = {32'(sa % sb), 32'(sa / sb)};
      default: p = {32'(ua % ub), 32'(ua / ub)};
    endcase
    return p;
  endfunction

  task automatic t_op(string req, logic [1:0] op, logic [31:0] a, logic [31:0] b);
    run_op(op, a, b);
    check(req, {hi_o, lo_o}, ref_res(op, a, b));
  endtask

  task automatic t_reset();
    check("R11 busy", {63'd0, busy_o}, 64'd0);
    check("R11 stall", {63'd0, stall_o}, 64'd0);
    check("R11 hilo", {hi_o, lo_o}, 64'd0);
  endtask

  task automatic t_unsigned_mul();
    t_op("R1", 2'b01, 32'd7, 32'd9);
    t_op("R1", 2'b01, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    t_op("R1", 2'b01, 32'h8000_0000, 32'd2);
    t_op("R1", 2'b01, 32'h1234_5678, 32'h9ABC_DEF0);
  endtask

  task automatic t_signed_mul();
    t_op("R2", 2'b00, 32'hFFFF_FFFF, 32'd5);
    t_op("R2", 2'b00, 32'hFFFF_FFF9, 32'hFFFF_FFFD);
    t_op("R2", 2'b00, 32'h8000_0000, 32'h8000_0000);
    t_op("R2", 2'b00, 32'h8000_0000, 32'hFFFF_FFFF);
    t_op("R2", 2'b00, 32'h0001_0000, 32'h8765_4321);
  endtask

  task automatic t_unsigned_div();
    t_op("R3", 2'b11, 32'd100, 32'd7);
    t_op("R3", 2'b11, 32'hFFFF_FFFF, 32'd1);
    t_op("R3", 2'b11, 32'd5, 32'd9);
    t_op("R3", 2'b11, 32'hDEAD_BEEF, 32'h0001_0003);
  endtask

  task automatic t_signed_div();
    t_op("R4", 2'b10, 32'd7, 32'd2);
    t_op("R4", 2'b10, -32'sd7, 32'd2);
    t_op("R4", 2'b10, 32'd7, -32'sd2);
    t_op("R4", 2'b10, -32'sd7, -32'sd2);
    t_op("R4", 2'b10, 32'h8000_0000, 32'hFFFF_FFFF);
    check("R4 minneg", {hi_o, lo_o}, {32'd0, 32'h8000_0000});
  endtask

  task automatic t_busy_window();
    run_op(2'b01, 32'd3, 32'd4);
    check("R5 busy cycles", 64'(busy_n), 64'd33);
    run_op(2'b10, -32'sd50, 32'd3);
    check("R5 busy cycles div", 64'(busy_n), 64'd33);
  endtask

  task automatic t_start_while_busy();
    @(negedge clk);
    start_i = 1'b1; op_i = 2'b01; a_i = 32'd3; b_i = 32'd5;
    @(negedge clk);
    op_i = 2'b11; a_i = 32'd100; b_i = 32'd7;
    @(negedge clk);
    start_i = 1'b0;
    busy_n = 2;
    while (busy_o && busy_n < 200) begin
      busy_n++;
      @(negedge clk);
    end
    check("R6 result", {hi_o, lo_o}, 64'd15);
    check("R6 window", 64'(busy_n - 1), 64'd33);
    @(negedge clk);
    check("R6 no rerun", {63'd0, busy_o}, 64'd0);
  endtask

  task automatic t_stall();
    @(negedge clk);
    rd_hi_i = 1'b1;
    check("R7 idle", {63'd0, stall_o}, 64'd0);
    start_i = 1'b1; op_i = 2'b01; a_i = 32'd2; b_i = 32'd2;
    @(negedge clk);
    start_i = 1'b0;
    check("R7 busy hi", {63'd0, stall_o}, 64'd1);
    rd_hi_i = 1'b0; rd_lo_i = 1'b1;
    #1;
    check("R7 busy lo", {63'd0, stall_o}, 64'd1);
    rd_lo_i = 1'b0;
    #1;
    check("R7 no read", {63'd0, stall_o}, 64'd0);
    while (busy_o) @(negedge clk);
    rd_lo_i = 1'b1;
    #1;
    check("R7 after", {63'd0, stall_o}, 64'd0);
    rd_lo_i = 1'b0;
  endtask

  task automatic t_direct_write();
    logic [31:0] lo_old;
    lo_old = lo_o;
    @(negedge clk);
    hi_we_i = 1'b1; hi_wdata_i = 32'hCAFE_0001;
    @(negedge clk);
    hi_we_i = 1'b0;
    check("R8 hi", {hi_o, lo_o}, {32'hCAFE_0001, lo_old});
    lo_we_i = 1'b1; lo_wdata_i = 32'hBEEF_0002;
    @(negedge clk);
    lo_we_i = 1'b0;
    check("R8 lo", {hi_o, lo_o}, {32'hCAFE_0001, 32'hBEEF_0002});
  endtask

  task automatic t_done_priority();
    @(negedge clk);
    start_i = 1'b1; op_i = 2'b01; a_i = 32'd6; b_i = 32'd7;
    @(posedge clk);
    repeat (32) @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    check("R9 still busy", {63'd0, busy_o}, 64'd1);
    hi_we_i = 1'b1; hi_wdata_i = 32'h1111_1111;
    lo_we_i = 1'b1; lo_wdata_i = 32'h2222_2222;
    @(negedge clk);
    hi_we_i = 1'b0; lo_we_i = 1'b0;
    check("R9 done", {63'd0, busy_o}, 64'd0);
    check("R9 result", {hi_o, lo_o}, 64'd42);
  endtask

  task automatic t_div_zero();
    run_op(2'b11, 32'd1234, 32'd0);
    check("R10 unsigned", 64'(busy_n), 64'd33);
    run_op(2'b10, -32'sd99, 32'd0);
    check("R10 signed", 64'(busy_n), 64'd33);
    t_op("R10 recover", 2'b11, 32'd81, 32'd9);
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; op_i = 2'b00; a_i = '0; b_i = '0;
    rd_hi_i = 1'b0; rd_lo_i = 1'b0; hi_we_i = 1'b0; lo_we_i = 1'b0;
    hi_wdata_i = '0; lo_wdata_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_unsigned_mul();
    t_signed_mul();
    t_unsigned_div();
    t_signed_div();
    t_busy_window();
    t_start_while_busy();
    t_stall();
    t_direct_write();
    t_done_priority();
    t_div_zero();
    done_flag = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule